// File: doc/BRIEF.md
# Transmission Fault Supervisor

This block watches a carrier transmission for faults while the bridge is driving. It deals with two kinds of fault. Protection faults are load dump, overcurrent in the high-side switch, overcurrent in the low-side switch and overtemperature. Each one is filtered by its own persistence counter. When a counter expires, the bridge is forced to tri-state straight away. Diagnostic faults are undervoltage, antenna peak current above the limit and a carrier frequency outside its window. These are only recorded.

Every fault seen during a transmission sets a single error latch. That latch becomes visible as an error-pending flag once the transmission ends, so that the interface logic can choose between an error reply and an acknowledge reply. The latch clears when that reply completes, or when the interface returns to standby.

The frequency check counts reference-clock cycles between rising edges of the carrier. With the default parameters and a 10 MHz reference, periods of 62 to 111 cycles are inside the window. Everything in the block runs on the reference clock. The carrier arrives as a data signal and is resynchronised inside the block.

Top module: `txn_fault_supervisor`

## Requirements
- R1: After reset, `bridge_tristate` and `err_pending` are both 0.
- R2: A protection flag (`prot_flags` bit 0 load dump, bit 1 high-side overcurrent, bit 2 low-side overcurrent, bit 3 overtemperature) sampled high on DEB_CYCLES consecutive clock edges while `tx_active` is 1 sets `bridge_tristate` on the following edge.
- R3: A protection flag that is high for fewer than DEB_CYCLES consecutive edges never sets `bridge_tristate`. A single low sample restarts the count.
- R4: While `tx_active` is 0, the protection and diagnostic flags have no effect on either output.
- R5: Once set, `bridge_tristate` stays at 1 after the flag goes away. It returns to 0 on the first edge at which `tx_active` is sampled 0.
- R6: While transmitting, a carrier period of PER_MIN to PER_MAX clock cycles (inclusive) between rising edges raises no error. A shorter or longer period is recorded as an error.
- R7: A carrier that shows no rising edge for more than PER_MAX cycles while transmitting is recorded as an error.
- R8: `uv_flag` or `peak_ov_flag` sampled high on any edge while transmitting is recorded as an error.
- R9: `err_pending` is 0 while `tx_active` is 1. It is 1 after `tx_active` falls if any protection trip or diagnostic error was recorded during that transmission.
- R10: `reply_done` or `standby` sampled high clears `err_pending` on that edge.
- R11: A transmission with no fault leaves `err_pending` at 0 after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_active | input | 1 | Bridge is driving (transmission in progress) |
| standby | input | 1 | Interface has returned to standby; clears the error latch |
| reply_done | input | 1 | End-of-sequence reply completed; clears the error latch |
| carrier | input | 1 | Carrier clock level, asynchronous to clk |
| prot_flags | input | 4 | Protection comparators: [0] load dump, [1] high-side OC, [2] low-side OC, [3] overtemperature |
| uv_flag | input | 1 | Supply undervoltage comparator |
| peak_ov_flag | input | 1 | Antenna peak current above limit comparator |
| bridge_tristate | output | 1 | Forces the half-bridge to high impedance |
| err_pending | output | 1 | Error to report at end of transmission |

## Verification
A debounce counter that is stuck or miscounts shows up at `bridge_tristate` one cycle away from the expected edge. The bench checks this at exactly DEB_CYCLES and at DEB_CYCLES+1 edges. A period counter that is off by one shows up only at the window edges. The bench therefore runs carriers of exactly PER_MIN, PER_MAX, PER_MIN-1 and PER_MAX+1 cycles and reads `err_pending` as soon as the transmission ends. A latch that fails to set, fails to clear, or leaks during transmission is visible at `err_pending` within one cycle of `tx_active` falling or of the clear pulse.

// File: rtl/txsup_pkg.sv
// Shared constants and types for the transmission fault supervisor.
// Assumes all protection comparators are presented as one vector.
package txsup_pkg;
    localparam int NUM_PROT   = 4;
    localparam int PF_LOADDMP = 0;
    localparam int PF_OC_HIGH = 1;
    localparam int PF_OC_LOW  = 2;
    localparam int PF_OVTEMP  = 3;

    typedef logic [NUM_PROT-1:0] prot_vec_t;
endpackage

// File: rtl/prot_debounce.sv
// Per-cause persistence filter. A trip is reported for a cause once its
// flag has been sampled high on DEB_CYCLES consecutive edges with enable set.
// Assumes flags are already synchronous to clk; enable low holds all counters at zero.
module prot_debounce #(
    parameter int N          = 4,
    parameter int DEB_CYCLES = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [N-1:0] flags,
    output logic [N-1:0] trip
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] DEB_V = CW'(DEB_CYCLES);

    for (genvar i = 0; i < N; i++) begin : g_cause
        logic [CW-1:0] cnt;

        // count consecutive high samples, saturating at the limit
        always_ff @(posedge clk) begin
            if (!rst_n || !enable || !flags[i]) begin
                cnt <= '0;
            end else if (cnt != DEB_V) begin
                cnt <= cnt + 1'b1;
            end
        end

        assign trip[i] = (cnt == DEB_V);

        // R3
        cnt_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0) |-> $past(enable && flags[i]));
        // R2
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= DEB_V);
    end
endmodule

// File: rtl/carrier_period_mon.sv
// Measures the carrier period in clk cycles between rising edges and flags
// periods outside [PER_MIN, PER_MAX]. A carrier that stops also flags once
// PER_MAX cycles pass without an edge. The first edge after enable only arms
// the low-bound check. Assumes the carrier is asynchronous and resynchronises it.
module carrier_period_mon #(
    parameter int PER_MIN = 62,
    parameter int PER_MAX = 111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic carrier,
    output logic freq_err
);
    localparam int CW = $clog2(PER_MAX + 2);
    localparam logic [CW-1:0] MIN_V = CW'(PER_MIN);
    localparam logic [CW-1:0] MAX_V = CW'(PER_MAX);

    logic          s1, s2, s3;
    logic          rise;
    logic          seen;
    logic [CW-1:0] cnt;
    logic [CW-1:0] per;

    // two-stage synchroniser plus edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= carrier;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 && !s3;
    assign per  = cnt + CW'(1);

    // cycle counter restarted on every rising edge, saturating at PER_MAX
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (rise) begin
            cnt  <= '0;
            seen <= 1'b1;
        end else if (cnt != MAX_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    // window compare on each edge, timeout between edges
    always_comb begin
        freq_err = 1'b0;
        if (enable) begin
            if (rise) begin
                freq_err = seen && ((per < MIN_V) || (per > MAX_V));
            end else begin
                freq_err = (cnt == MAX_V);
            end
        end
    end

    // R7
    per_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_V);
    // R6
    arm_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen) |-> $past(enable));
endmodule

// File: rtl/err_latch.sv
// Sticky error record for one transmission. Set while transmitting, cleared
// by the reply-complete or standby pulse; clear wins over set.
// Assumes the set input is already qualified by the caller.
module err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_q
);
    // hold the error until the reply or standby clears it
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_q <= 1'b0;
        end else if (set_i) begin
            err_q <= 1'b1;
        end
    end

    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !err_q);
endmodule

// File: rtl/txn_fault_supervisor.sv
// Top of the transmission fault supervisor. Debounced protection trips force
// the bridge to tri-state until the transmission ends; all faults feed one
// error latch that is exposed only after tx_active falls.
// Assumes comparator flags are synchronous to clk; the carrier may be asynchronous.
module txn_fault_supervisor
    import txsup_pkg::*;
#(
    parameter int DEB_CYCLES = 200,
    parameter int PER_MIN    = 62,
    parameter int PER_MAX    = 111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_active,
    input  logic                standby,
    input  logic                reply_done,
    input  logic                carrier,
    input  logic [NUM_PROT-1:0] prot_flags,
    input  logic                uv_flag,
    input  logic                peak_ov_flag,
    output logic                bridge_tristate,
    output logic                err_pending
);
    prot_vec_t trip;
    logic      any_trip;
    logic      freq_err;
    logic      shut_q;
    logic      err_set;
    logic      err_q;

    prot_debounce #(
        .N          (NUM_PROT),
        .DEB_CYCLES (DEB_CYCLES)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tx_active),
        .flags  (prot_flags),
        .trip   (trip)
    );

    carrier_period_mon #(
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX)
    ) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_active),
        .carrier  (carrier),
        .freq_err (freq_err)
    );

    assign any_trip = |trip;

    // shutdown latch: set by any trip, released when transmission stops
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_active) begin
            shut_q <= 1'b0;
        end else if (any_trip) begin
            shut_q <= 1'b1;
        end
    end

    assign err_set = tx_active && (any_trip || freq_err || uv_flag || peak_ov_flag);

    err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (reply_done || standby),
        .err_q (err_q)
    );

    assign bridge_tristate = shut_q;
    assign err_pending     = err_q && !tx_active;

    // R5
    shut_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> !bridge_tristate);
    // R4
    shut_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bridge_tristate) |-> $past(tx_active));
    // R2
    shut_records_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bridge_tristate) |-> err_q);
    // R10
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_done || standby) |=> !err_pending);
endmodule

// File: tb/tb_txn_fault_supervisor.sv
module tb_txn_fault_supervisor;
    localparam int DEB  = 200;
    localparam int PMIN = 62;
    localparam int PMAX = 111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_active = 1'b0;
    logic       standby = 1'b0;
    logic       reply_done = 1'b0;
    logic       carrier;
    logic [3:0] prot_flags = 4'b0;
    logic       uv_flag = 1'b0;
    logic       peak_ov_flag = 1'b0;
    logic       bridge_tristate;
    logic       err_pending;

    int total = 0;
    int bad = 0;
    int car_hi = 40;
    int car_lo = 40;
    bit car_stop = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    txn_fault_supervisor #(
        .DEB_CYCLES (DEB),
        .PER_MIN    (PMIN),
        .PER_MAX    (PMAX)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_active       (tx_active),
        .standby         (standby),
        .reply_done      (reply_done),
        .carrier         (carrier),
        .prot_flags      (prot_flags),
        .uv_flag         (uv_flag),
        .peak_ov_flag    (peak_ov_flag),
        .bridge_tristate (bridge_tristate),
        .err_pending     (err_pending)
    );

    // carrier source driven at falling edges
    initial begin
        carrier = 1'b0;
        forever begin
            if (car_stop) begin
                carrier = 1'b0;
                @(negedge clk);
            end else begin
                carrier = 1'b1;
                repeat (car_hi) @(negedge clk);
                carrier = 1'b0;
                repeat (car_lo) @(negedge clk);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_period(input int p);
        car_hi = p / 2;
        car_lo = p - p / 2;
        repeat (3 * p) @(negedge clk);
    endtask

    task automatic tx_begin();
        @(negedge clk);
        tx_active = 1'b1;
    endtask

    task automatic tx_end();
        tx_active = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_by_standby();
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1 tristate after reset", bridge_tristate, 0);
        chk("R1 err_pending after reset", err_pending, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_trip(input int bitn);
        tx_begin();
        repeat (5) @(negedge clk);
        prot_flags[bitn] = 1'b1;
        repeat (DEB) @(negedge clk);
        chk($sformatf("R2 no trip at DEB edges bit%0d", bitn), bridge_tristate, 0);
        @(negedge clk);
        chk($sformatf("R2 trip at DEB+1 edges bit%0d", bitn), bridge_tristate, 1);
        chk("R9 pending hidden during tx", err_pending, 0);
        prot_flags[bitn] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 tristate held after flag drops", bridge_tristate, 1);
        tx_active = 1'b0;
        @(negedge clk);
        chk("R5 tristate released after tx ends", bridge_tristate, 0);
        chk("R9 pending after trip", err_pending, 1);
        reply_done = 1'b1;
        @(negedge clk);
        reply_done = 1'b0;
        chk("R10 reply_done clears pending", err_pending, 0);
        @(negedge clk);
    endtask

    task automatic t_glitch();
        tx_begin();
        prot_flags[2] = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        prot_flags[2] = 1'b0;
        @(negedge clk);
        prot_flags[2] = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        prot_flags[2] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R3 short faults do not trip", bridge_tristate, 0);
        tx_end();
        chk("R3 short faults leave no error", err_pending, 0);
    endtask

    task automatic t_idle_ignore();
        prot_flags = 4'hF;
        uv_flag = 1'b1;
        peak_ov_flag = 1'b1;
        repeat (DEB + 20) @(negedge clk);
        chk("R4 idle flags no tristate", bridge_tristate, 0);
        chk("R4 idle flags no error", err_pending, 0);
        prot_flags = 4'h0;
        uv_flag = 1'b0;
        peak_ov_flag = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_freq(input int p, input int exp);
        set_period(p);
        tx_begin();
        repeat (10 * p) @(negedge clk);
        tx_end();
        chk($sformatf("R6 period %0d", p), err_pending, exp);
        clear_by_standby();
        chk("R10 standby clears pending", err_pending, 0);
    endtask

    task automatic t_stop();
        set_period(80);
        tx_begin();
        repeat (200) @(negedge clk);
        car_stop = 1'b1;
        repeat (300) @(negedge clk);
        tx_end();
        chk("R7 stopped carrier flagged", err_pending, 1);
        car_stop = 1'b0;
        clear_by_standby();
        set_period(80);
    endtask

    task automatic t_diag(input bit use_uv);
        tx_begin();
        repeat (20) @(negedge clk);
        if (use_uv) uv_flag = 1'b1; else peak_ov_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        peak_ov_flag = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 diag does not tristate", bridge_tristate, 0);
        chk("R9 pending hidden during tx", err_pending, 0);
        tx_end();
        chk(use_uv ? "R8 undervoltage error" : "R8 peak current error", err_pending, 1);
        repeat (5) @(negedge clk);
        chk("R9 pending held until cleared", err_pending, 1);
        clear_by_standby();
    endtask

    task automatic t_clean();
        tx_begin();
        repeat (1000) @(negedge clk);
        tx_end();
        chk("R11 clean transmission no error", err_pending, 0);
    endtask

    initial begin
        t_reset();
        set_period(80);
        t_clean();
        for (int b = 0; b < 4; b++) t_trip(b);
        t_glitch();
        t_idle_ignore();
        t_freq(PMIN, 0);
        t_freq(PMAX, 0);
        t_freq(PMIN - 1, 1);
        t_freq(PMAX + 1, 1);
        set_period(80);
        t_stop();
        t_diag(1'b1);
        t_diag(1'b0);
        t_clean();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule